// File: doc/BRIEF.md
# Two-Channel Table-Divided Pulse Generator

This block produces up to two pulse-width-modulated outputs from one input clock. Software programs it through a 32-bit register write/read port. One shared control word holds a 15-bit field group for each channel: a prescaler code, run and gate bits, and an output level select. Each channel also has its own timing word, which holds the period (stored as length minus one) and the duty count.

For each channel, a prescaler turns the input clock into ticks. It uses either one of a fixed set of large non-power-of-two ratios or, where the build allows it, a straight divide-by-one. A 16-bit counter steps on every tick and wraps after the programmed number of ticks. The output is in its active level while that counter is below the duty count.

A new timing word does not disturb a waveform already running. It is held in a staging copy until the current period finishes. A busy flag in the control word shows that the staged value has not yet been applied.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: After reset every stored bit is zero: the control word reads 0x00000000, both timing words read 0x00000000, and since a zero level-select bit means inverted output, both pins sit at 1.
- R2: Prescaler codes in bits [3:0] of a channel field map to clock ratios as follows: 0:120, 1:180, 2:240, 3:360, 4:480, 8:12000, 9:24000, 10:36000, 11:48000, 12:72000. Code 15 gives ratio 1 when HAS_BYPASS is 1. The counter advances once per ratio input clocks.
- R3: Codes 5, 6, 7, 13, 14 are invalid, and so is code 15 when HAS_BYPASS is 0. With an invalid code the pin holds its inactive level and the channel counters stay at zero.
- R4: The timing word keeps period minus one in bits [31:16] and the duty count in bits [15:0]. Each period lasts field+1 ticks. With bit 5 (level select) at 1, the pin is high for exactly duty ticks of each period, starting at count zero.
- R5: A duty count greater than the period field (duty >= period length) makes the pin stay continuously active.
- R6: Bit 5 of a channel field at 0 inverts the pin: it is low for duty ticks and high for the rest, and it idles at 1.
- R7: A channel counts only while gate (bit 6) is 1 and drives its waveform only while both gate and enable (bit 4) are 1. Otherwise the pin holds the inactive level, which is the inverse of bit 5.
- R8: Clearing gate returns both the prescale and period counters to zero. After gate is set again, the first period starts at count zero, so the pin is active for duty times ratio clocks.
- R9: A timing-word write is staged. Control bit 28+n reads 1 while channel n holds a staged value that is not yet applied. The value is applied when the running period wraps, or on the next clock if the channel is not counting. The flag then reads 0.
- R10: The control word is at address 0x0, and channel n's timing word is at 0x4+4n. Channel n's field occupies control bits [15n+9:15n], and these bits read back as written. Control bits outside the channel fields and the busy flags read 0. A timing word reads back the last value written to it. The channels run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_pin | output | NUM_CH | One waveform output per channel |

## Verification
A register write lands on the clock edge that samples it. Pins are combinational from the counters, so the first sample after a write that starts a channel already shows count zero. The count then advances one clock after each prescale tick: every clock in divide-by-one, and every ratio clocks otherwise.

A staged timing value is applied on the clock edge that wraps the period, or one clock later for an idle channel. The busy flag is therefore read right after the write, and read again only after a wait longer than one period.

Duty and period are measured in two ways that do not depend on phase:
- by counting active samples over windows that span a whole number of periods;
- by measuring the length of the first active run after the gate is set.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

    localparam int REG_W     = 32;
    localparam int FIELD_W   = 15;   // stride of one channel inside the control word
    localparam int CFG_W     = 10;   // implemented bits of one channel field
    localparam int CODE_W    = 4;
    localparam int CNT_W     = 16;
    localparam int PS_W      = 17;   // holds the largest ratio (72000)
    localparam int BUSY_BASE = 28;

    // Field layout of one channel, MSB first: bits 9..0
    typedef struct packed {
        logic              rsv_bypass;  // stored only
        logic              rsv_pulse;   // stored only
        logic              rsv_mode;    // stored only
        logic              gate;        // bit 6
        logic              lvl_hi;      // bit 5: 1 = active high
        logic              run;         // bit 4
        logic [CODE_W-1:0] code;        // bits 3..0
    } ch_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] len_m1;  // bits 31..16
        logic [CNT_W-1:0] duty;    // bits 15..0
    } ch_timing_t;

    // Clock ratio for a prescaler code; zero marks an invalid code.
    function automatic logic [PS_W-1:0] ratio_of(input logic [CODE_W-1:0] code,
                                                 input bit has_bypass);
        logic [PS_W-1:0] r;
        case (code)
            4'd0:    r = 17'd120;
            4'd1:    r = 17'd180;
            4'd2:    r = 17'd240;
            4'd3:    r = 17'd360;
            4'd4:    r = 17'd480;
            4'd8:    r = 17'd12000;
            4'd9:    r = 17'd24000;
            4'd10:   r = 17'd36000;
            4'd11:   r = 17'd48000;
            4'd12:   r = 17'd72000;
            4'd15:   r = has_bypass ? 17'd1 : 17'd0;
            default: r = 17'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmx_prescaler.sv
module pwmx_prescaler
    import pwmx_pkg::*;
#(
    parameter bit HAS_BYPASS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              gate,
    output logic              tick,
    output logic              code_ok
);

    logic [PS_W-1:0] ratio;
    logic [PS_W-1:0] pc;
    logic            active;
    logic            at_end;

    assign ratio   = ratio_of(code, HAS_BYPASS);
    assign code_ok = (ratio != '0);
    assign active  = gate && code_ok;
    assign at_end  = (pc >= ratio - 1'b1);
    assign tick    = active && at_end;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pc <= '0;
        end else if (at_end) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // R3 / R8: a stopped or invalid prescaler is parked at zero
    p_pc_parked_r3: assert property (@(posedge clk) disable iff (rst)
        !active |=> (pc == '0));

    // R2: with a ratio above one, ticks never come back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && ratio > 17'd1) |=> (!tick || $changed(code)));

endmodule

// File: rtl/pwmx_channel.sv
module pwmx_channel
    import pwmx_pkg::*;
#(
    parameter bit HAS_BYPASS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              gate,
    input  logic              run,
    input  logic              lvl_hi,
    input  logic              tw_we,
    input  ch_timing_t        tw_wdata,
    output ch_timing_t        tw_staged,
    output logic              busy,
    output logic              pin
);

    logic             tick;
    logic             code_ok;
    logic             counting;
    logic             driving;
    logic             wrap;
    logic             apply_ok;
    logic             in_duty;
    logic [CNT_W-1:0] cnt;
    ch_timing_t       live;

    pwmx_prescaler #(.HAS_BYPASS(HAS_BYPASS)) u_ps (
        .clk     (clk),
        .rst     (rst),
        .code    (code),
        .gate    (gate),
        .tick    (tick),
        .code_ok (code_ok)
    );

    assign counting = gate && code_ok;
    assign driving  = counting && run;
    assign wrap     = tick && (cnt == live.len_m1);
    assign apply_ok = !counting || wrap;

    // staging copy and the live copy used by the counter
    always_ff @(posedge clk) begin
        if (rst) begin
            tw_staged <= '0;
            live      <= '0;
            busy      <= 1'b0;
        end else if (tw_we) begin
            tw_staged <= tw_wdata;
            busy      <= 1'b1;
        end else if (busy && apply_ok) begin
            live <= tw_staged;
            busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !counting) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    assign in_duty = driving && (cnt < live.duty);
    assign pin     = lvl_hi ? in_duty : !in_duty;

    // R4: the period counter never passes the live period field
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= live.len_m1);

    // R5: duty beyond the period keeps the pin at the active level
    p_full_duty_r5: assert property (@(posedge clk) disable iff (rst)
        (driving && live.duty > live.len_m1) |-> (pin == lvl_hi));

    // R8: dropping the gate clears the period count
    p_gate_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(gate) |=> (cnt == '0));

    // R9: the live timing only changes at a wrap or while idle
    p_live_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (counting && !wrap) |=> $stable(live));

endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
    import pwmx_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter bit HAS_BYPASS = 1'b1,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] pwm_pin
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
    localparam int                TW_STEP   = 4;

    ch_cfg_t    cfg_q  [NUM_CH];
    ch_timing_t staged [NUM_CH];
    logic       busy   [NUM_CH];
    logic       ctrl_we;

    assign ctrl_we = bus_we && (bus_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_CH; n++) begin
            if (rst) begin
                cfg_q[n] <= '0;
            end else if (ctrl_we) begin
                cfg_q[n] <= bus_wdata[FIELD_W*n +: CFG_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] TW_ADDR = ADDR_W'(TW_STEP * (g + 1));
        logic tw_we;
        assign tw_we = bus_we && (bus_addr == TW_ADDR);

        pwmx_channel #(.HAS_BYPASS(HAS_BYPASS)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .code      (cfg_q[g].code),
            .gate      (cfg_q[g].gate),
            .run       (cfg_q[g].run),
            .lvl_hi    (cfg_q[g].lvl_hi),
            .tw_we     (tw_we),
            .tw_wdata  (bus_wdata),
            .tw_staged (staged[g]),
            .busy      (busy[g]),
            .pin       (pwm_pin[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            for (int n = 0; n < NUM_CH; n++) begin
                bus_rdata[FIELD_W*n +: CFG_W] = cfg_q[n];
                bus_rdata[BUSY_BASE + n]      = busy[n];
            end
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(TW_STEP * (n + 1))) begin
                bus_rdata = staged[n];
            end
        end
    end

    // R7: an ungated channel shows its inactive level
    p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q[0].gate) |-> (pwm_pin[0] == !cfg_q[0].lvl_hi));

    // R1: out of reset the control state is cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (cfg_q[0] == '0));

endmodule

// File: tb/sim_pwm_dual_ctrl.sv
module sim_pwm_dual_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we0 = 1'b0, we1 = 1'b0;
    logic [3:0]  ad0 = '0,   ad1 = '0;
    logic [31:0] wd0 = '0,   wd1 = '0;
    logic [31:0] rd0, rd1;
    logic [1:0]  pin0, pin1;
    int          n_run = 0, n_fail = 0;
    bit          done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pwm_dual_ctrl u0 (
        .clk(clk), .rst(rst), .bus_we(we0), .bus_addr(ad0),
        .bus_wdata(wd0), .bus_rdata(rd0), .pwm_pin(pin0));

    pwm_dual_ctrl #(.HAS_BYPASS(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_we(we1), .bus_addr(ad1),
        .bus_wdata(wd1), .bus_rdata(rd1), .pwm_pin(pin1));

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (sel) begin we1 = 1'b1; ad1 = a; wd1 = d; end
        else     begin we0 = 1'b1; ad0 = a; wd0 = d; end
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [3:0] a, output logic [31:0] d);
        if (sel) ad1 = a; else ad0 = a;
        #0.5;
        d = sel ? rd1 : rd0;
    endtask

    task automatic window(input bit sel, input int ch, input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if ((sel ? pin1[ch] : pin0[ch]) === 1'b1) hi++;
        end
    endtask

    // length of the active run that starts at the current sample
    task automatic first_run(input int limit, output int len);
        len = 0;
        while (pin0[0] === 1'b1 && len < limit) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, 4'h0, d); check("R1 ctrl", d, 0);
        rd(0, 4'h4, d); check("R1 tw0", d, 0);
        rd(0, 4'h8, d); check("R1 tw1", d, 0);
        check("R1 pins", pin0, 2'b11);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(0, 4'h0, 32'hFFFF_FFFF);
        rd(0, 4'h0, d); check("R10 ctrl readback", d, 32'h01FF_83FF);
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h8, 32'h1234_5678);
        rd(0, 4'h8, d); check("R10 tw1 readback", d, 32'h1234_5678);
        rd(0, 4'h4, d); check("R10 tw0 untouched", d, 0);
        wr(0, 4'h8, 32'h0);
    endtask

    task automatic t_duty_polarity();
        int hi;
        wr(0, 4'h4, 32'h0009_0003);
        wr(0, 4'h0, 32'h0000_007F);
        window(0, 0, 50, hi); check("R4 bypass duty 3/10", hi, 15);
        wr(0, 4'h0, 32'h0000_005F);
        window(0, 0, 50, hi); check("R6 inverted duty", hi, 35);
        wr(0, 4'h4, 32'h0004_0007);
        wr(0, 4'h0, 32'h0000_007F);
        repeat (8) @(negedge clk);
        window(0, 0, 20, hi); check("R5 duty over period", hi, 20);
    endtask

    task automatic t_enable_gate();
        int hi;
        wr(0, 4'h4, 32'h0009_0003);
        wr(0, 4'h0, 32'h0000_006F);
        window(0, 0, 20, hi); check("R7 gate only", hi, 0);
        wr(0, 4'h0, 32'h0000_003F);
        window(0, 0, 20, hi); check("R7 enable only", hi, 0);
        wr(0, 4'h0, 32'h0000_004F);
        window(0, 0, 20, hi); check("R7 inverted idle level", hi, 20);
    endtask

    task automatic t_table();
        int len, hi;
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h4, 32'h0003_0002);
        wr(0, 4'h0, 32'h0000_0070);
        first_run(100000, len); check("R2 code0 first run", len, 240);
        window(0, 0, 960, hi); check("R2 code0 window", hi, 480);
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h4, 32'h0001_0001);
        wr(0, 4'h0, 32'h0000_0073);
        first_run(100000, len); check("R2 code3 ratio 360", len, 360);
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h0, 32'h0000_0074);
        first_run(100000, len); check("R2 code4 ratio 480", len, 480);
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h0, 32'h0000_0078);
        first_run(100000, len); check("R2 code8 ratio 12000", len, 12000);
    endtask

    task automatic t_regate();
        int len;
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h4, 32'h0003_0002);
        wr(0, 4'h0, 32'h0000_0070);
        repeat (300) @(negedge clk);
        wr(0, 4'h0, 32'h0000_0030);
        repeat (3) @(negedge clk);
        wr(0, 4'h0, 32'h0000_0070);
        first_run(100000, len); check("R8 fresh phase after regate", len, 240);
    endtask

    task automatic t_shadow();
        logic [31:0] d;
        int hi;
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h4, 32'h0009_0003);
        wr(0, 4'h0, 32'h0000_007F);
        repeat (4) @(negedge clk);
        wr(0, 4'h4, 32'h0013_000F);
        rd(0, 4'h0, d); check("R9 busy while staged", d[28], 1);
        repeat (12) @(negedge clk);
        rd(0, 4'h0, d); check("R9 busy cleared at wrap", d[28], 0);
        window(0, 0, 40, hi); check("R9 new timing live", hi, 30);
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h4, 32'h0009_0003);
        rd(0, 4'h0, d); check("R9 idle busy set", d[28], 1);
        @(negedge clk);
        rd(0, 4'h0, d); check("R9 idle apply next clock", d[28], 0);
    endtask

    task automatic t_invalid();
        int hi;
        wr(0, 4'h0, 32'h0000_0075);
        window(0, 0, 30, hi); check("R3 code5 held", hi, 0);
        wr(0, 4'h0, 32'h0000_007D);
        window(0, 0, 30, hi); check("R3 code13 held", hi, 0);
        wr(0, 4'h0, 32'h0000_0056);
        window(0, 0, 30, hi); check("R3 code6 inverted idle", hi, 30);
        wr(1, 4'h4, 32'h0009_0003);
        wr(1, 4'h0, 32'h0000_007F);
        window(1, 0, 30, hi); check("R3 code15 without bypass", hi, 0);
    endtask

    task automatic t_two_ch();
        int hi;
        wr(0, 4'h0, 32'h0);
        wr(0, 4'h4, 32'h0009_0003);
        wr(0, 4'h8, 32'h0004_0001);
        wr(0, 4'h0, 32'h003F_807F);
        repeat (2) @(negedge clk);
        window(0, 0, 100, hi); check("R10 ch0 independent", hi, 30);
        window(0, 1, 100, hi); check("R10 ch1 independent", hi, 20);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_duty_polarity();
        t_enable_gate();
        t_table();
        t_regate();
        t_shadow();
        t_invalid();
        t_two_ch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule